// File: doc/BRIEF.md
# GPIO Expander Interrupt and Mask Logic

This block is the interrupt path of an 8-bit I/O expander. Eight asynchronous input pins pass through a two-stage synchronizer. Each synchronized pin is compared against a reference snapshot, which is taken each time software reads the input port register. A difference sets a sticky per-pin pending flag. A single active-low interrupt line is asserted while any pending pin has its mask bit cleared.

The mask acts on pending events and not only on new ones. Unmasking a pin that has already changed raises the interrupt in the next cycle. Masking the pin that is the only current source drops the interrupt again.

A byte-wide register port gives access to several registers: the input port (read-only), the per-pin input latch enable, the pull enable, the pull direction select and the interrupt mask. The block also drives per-pin pull-up and pull-down enables for the pad ring. These enables are forced off on pins that are in open-drain output mode.

Top module: `gpx_irq_top`

## Requirements
- R1: After reset the mask register (45h) reads FFh, the latch (42h), pull enable (43h) and pull select (44h) registers read 00h, `irqN` is 1 and both pull outputs are 00h.
- R2: When a pin whose mask bit is 0 changes level, `irqN` goes to 0 by the third rising clock edge after the change.
- R3: When a pin whose mask bit is 1 changes level, `irqN` stays 1.
- R4: Writing 0 to the mask bit of a pin that holds a pending change drives `irqN` to 0 in the cycle after the write.
- R5: Setting the mask bit of the pin that is the interrupt source drives `irqN` back to 1 in the cycle after the write, unless another unmasked pin is still pending.
- R6: A read of address 00h returns the synchronized pin levels (bit i = pin i), clears every pending flag, and leaves `irqN` at 1 in the next cycle.
- R7: When latch bit i (42h) is 1 and pin i is pending, the 00h read returns the level captured at the first change, even if the pin has since returned. When the latch bit is 0, the read returns the current level.
- R8: Per pin: a pull enable bit of 0 turns both pulls off. Enable 1 with select 1 turns on `pullUpEn`, and enable 1 with select 0 turns on `pullDnEn`.
- R9: A pin with `odMode` bit 1 has both `pullUpEn` and `pullDnEn` at 0, whatever the enable and select bits hold.
- R10: Reads of any address other than 00h and 42h–45h return 00h. Writes to those addresses, and writes to 00h, change no register.
- R11: Registers 42h–45h read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Asynchronous input pin levels |
| odMode | input | 8 | Per-pin open-drain output mode, forces pulls off |
| addr | input | 8 | Register address |
| wrData | input | 8 | Register write data |
| wrStrobe | input | 1 | Write strobe, one cycle per write |
| rdStrobe | input | 1 | Read strobe, one cycle per read (side effects only) |
| rdData | output | 8 | Read data for `addr`, combinational |
| irqN | output | 1 | Active-low interrupt |
| pullUpEn | output | 8 | Per-pin pull-up enable |
| pullDnEn | output | 8 | Per-pin pull-down enable |

## Verification
On every cycle, the assertions check four things:
- no pull is ever enabled on an open-drain pin;
- a fully set mask always keeps the interrupt released;
- an input-port read always releases it one cycle later;
- a mask write that uncovers a pending pin always raises it.

They also check that writes to unmapped addresses leave the mask untouched. Only the bench scenarios can show the rest: the synchronizer latency from a pin edge to the interrupt, the value a latched pin returns after it bounces back, read-back of every register, and the full sweep of pull enable, select and open-drain combinations.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  localparam int PIN_COUNT   = 8;
  localparam int ADDR_BITS   = 8;
  localparam int SYNC_DEPTH  = 2;

  // Register addresses: the input port, then the block of config registers
  localparam int ADDR_PORT    = 'h00;
  localparam int ADDR_LATCH   = 'h42;
  localparam int ADDR_PULLEN  = 'h43;
  localparam int ADDR_PULLSEL = 'h44;
  localparam int ADDR_MASK    = 'h45;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PORT,
    SEL_LATCH,
    SEL_PULLEN,
    SEL_PULLSEL,
    SEL_MASK
  } rdSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   portRead;
    logic   wrLatch;
    logic   wrPullEn;
    logic   wrPullSel;
    logic   wrMask;
    rdSel_t rdSel;
  } regStrobes_t;

endpackage

// File: rtl/gpx_cfg_reg.sv
module gpx_cfg_reg #(
  parameter int             W         = 8,
  parameter logic [W-1:0]   RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   q <= RESET_VAL;
    else if (we) q <= d;
  end

endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
  import gpx_pkg::*;
#(
  parameter int ADDR_W = ADDR_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  output regStrobes_t       strb
);

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    unique case (addr)
      ADDR_W'(ADDR_PORT):    strb.rdSel = SEL_PORT;
      ADDR_W'(ADDR_LATCH):   strb.rdSel = SEL_LATCH;
      ADDR_W'(ADDR_PULLEN):  strb.rdSel = SEL_PULLEN;
      ADDR_W'(ADDR_PULLSEL): strb.rdSel = SEL_PULLSEL;
      ADDR_W'(ADDR_MASK):    strb.rdSel = SEL_MASK;
      default:               strb.rdSel = SEL_NONE;
    endcase
    // Input port is read-only; only its read has a side effect
    strb.portRead  = rdStrobe && (strb.rdSel == SEL_PORT);
    strb.wrLatch   = wrStrobe && (strb.rdSel == SEL_LATCH);
    strb.wrPullEn  = wrStrobe && (strb.rdSel == SEL_PULLEN);
    strb.wrPullSel = wrStrobe && (strb.rdSel == SEL_PULLSEL);
    strb.wrMask    = wrStrobe && (strb.rdSel == SEL_MASK);
  end

endmodule

// File: rtl/gpx_datapath.sv
module gpx_datapath
  import gpx_pkg::*;
#(
  parameter int NPINS  = PIN_COUNT,
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] odMode,
  input  logic [NPINS-1:0] wrData,
  input  regStrobes_t      strb,
  output logic [NPINS-1:0] rdData,
  output logic             irqN,
  output logic [NPINS-1:0] pullUpEn,
  output logic [NPINS-1:0] pullDnEn,
  output logic [NPINS-1:0] maskVal,
  output logic [NPINS-1:0] pendingVal
);

  localparam logic [NPINS-1:0] MASK_RESET = '1;

  // Synchronizer chain
  logic [STAGES-1:0][NPINS-1:0] syncPipe;
  logic [NPINS-1:0]             pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
    end else begin
      syncPipe[0] <= pinIn;
      for (int k = 1; k < STAGES; k++) syncPipe[k] <= syncPipe[k-1];
    end
  end
  assign pinSync = syncPipe[STAGES-1];

  // Configuration registers
  logic [NPINS-1:0] latchReg, pullEnReg, pullSelReg, maskReg;

  gpx_cfg_reg #(.W(NPINS), .RESET_VAL('0)) i_latch (
    .clk(clk), .rstN(rstN), .we(strb.wrLatch), .d(wrData), .q(latchReg));
  gpx_cfg_reg #(.W(NPINS), .RESET_VAL('0)) i_pullEn (
    .clk(clk), .rstN(rstN), .we(strb.wrPullEn), .d(wrData), .q(pullEnReg));
  gpx_cfg_reg #(.W(NPINS), .RESET_VAL('0)) i_pullSel (
    .clk(clk), .rstN(rstN), .we(strb.wrPullSel), .d(wrData), .q(pullSelReg));
  gpx_cfg_reg #(.W(NPINS), .RESET_VAL(MASK_RESET)) i_mask (
    .clk(clk), .rstN(rstN), .we(strb.wrMask), .d(wrData), .q(maskReg));

  // Change detection against the snapshot taken at the last port read
  logic [NPINS-1:0] refVal, pending, capVal, portView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              refVal <= '0;
    else if (strb.portRead) refVal <= pinSync;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic diff;
    assign diff = pinSync[i] ^ refVal[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pending[i] <= 1'b0;
        capVal[i]  <= 1'b0;
      end else begin
        if (strb.portRead)  pending[i] <= 1'b0;
        else if (diff)      pending[i] <= 1'b1;
        // Capture the level seen at the first change only
        if (!pending[i] && diff) capVal[i] <= pinSync[i];
      end
    end

    assign portView[i] = (latchReg[i] && pending[i]) ? capVal[i] : pinSync[i];
    assign pullUpEn[i] = pullEnReg[i] &&  pullSelReg[i] && !odMode[i];
    assign pullDnEn[i] = pullEnReg[i] && !pullSelReg[i] && !odMode[i];
  end

  // Masking acts on held events, so mask writes take effect at once
  assign irqN = ~|(pending & ~maskReg);

  always_comb begin
    unique case (strb.rdSel)
      SEL_PORT:    rdData = portView;
      SEL_LATCH:   rdData = latchReg;
      SEL_PULLEN:  rdData = pullEnReg;
      SEL_PULLSEL: rdData = pullSelReg;
      SEL_MASK:    rdData = maskReg;
      default:     rdData = '0;
    endcase
  end

  assign maskVal    = maskReg;
  assign pendingVal = pending;

endmodule

// File: rtl/gpx_irq_top.sv
module gpx_irq_top
  import gpx_pkg::*;
#(
  parameter int NPINS  = PIN_COUNT,
  parameter int ADDR_W = ADDR_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPINS-1:0]  pinIn,
  input  logic [NPINS-1:0]  odMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wrData,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  output logic [NPINS-1:0]  rdData,
  output logic              irqN,
  output logic [NPINS-1:0]  pullUpEn,
  output logic [NPINS-1:0]  pullDnEn
);

  regStrobes_t      strb;
  logic [NPINS-1:0] maskVal;
  logic [NPINS-1:0] pendingVal;

  gpx_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .addr(addr), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .strb(strb));

  gpx_datapath #(.NPINS(NPINS), .STAGES(SYNC_DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .odMode(odMode), .wrData(wrData),
    .strb(strb), .rdData(rdData), .irqN(irqN), .pullUpEn(pullUpEn),
    .pullDnEn(pullDnEn), .maskVal(maskVal), .pendingVal(pendingVal));

endmodule

// File: rtl/gpx_irq_checker.sv
module gpx_irq_checker
  import gpx_pkg::*;
#(
  parameter int NPINS  = PIN_COUNT,
  parameter int ADDR_W = ADDR_BITS
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  wrData,
  input logic              wrStrobe,
  input logic              rdStrobe,
  input logic              irqN,
  input logic [NPINS-1:0]  pullUpEn,
  input logic [NPINS-1:0]  pullDnEn,
  input logic [NPINS-1:0]  odMode,
  input logic [NPINS-1:0]  maskVal,
  input logic [NPINS-1:0]  pendingVal
);

  logic mappedWr;
  assign mappedWr = (addr == ADDR_W'(ADDR_LATCH))   || (addr == ADDR_W'(ADDR_PULLEN)) ||
                    (addr == ADDR_W'(ADDR_PULLSEL)) || (addr == ADDR_W'(ADDR_MASK));

  // R1: interrupt released when reset ends
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> irqN);

  // R3: all pins masked keeps the line released
  a_r3_all_masked: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVal) |-> irqN);

  // R4: uncovering a pending pin raises the interrupt next cycle
  a_r4_unmask_raises: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && addr == ADDR_W'(ADDR_MASK) && |(pendingVal & ~wrData)) |=> !irqN);

  // R5: masking every pin releases the interrupt next cycle
  a_r5_mask_releases: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && addr == ADDR_W'(ADDR_MASK) && (&wrData)) |=> irqN);

  // R6: input port read releases the interrupt next cycle
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && addr == ADDR_W'(ADDR_PORT)) |=> irqN);

  // R9: open-drain pins never have a pull
  a_r9_od_no_pull: assert property (@(posedge clk) disable iff (!rstN)
    (odMode & (pullUpEn | pullDnEn)) == '0);

  // R10: writes outside the map leave the mask alone
  a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !mappedWr) |=> $stable(maskVal));

endmodule

bind gpx_irq_top gpx_irq_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrStrobe(wrStrobe),
  .rdStrobe(rdStrobe), .irqN(irqN), .pullUpEn(pullUpEn), .pullDnEn(pullDnEn),
  .odMode(odMode), .maskVal(maskVal), .pendingVal(pendingVal));

// File: tb/test_gpx_irq_top.sv
`timescale 1ns/1ps
module test_gpx_irq_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] pins, od, addr, wrData, rdData, pullUpEn, pullDnEn;
  logic       wrStrobe, rdStrobe, irqN;
  int         nChecks = 0;
  int         nFails  = 0;
  bit         done    = 1'b0;

  always #2 clk = ~clk;

  gpx_irq_top i_gpx_irq_top (
    .clk(clk), .rstN(rstN), .pinIn(pins), .odMode(od), .addr(addr),
    .wrData(wrData), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .rdData(rdData),
    .irqN(irqN), .pullUpEn(pullUpEn), .pullDnEn(pullDnEn));

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic writeReg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0;
  endtask

  task automatic readReg(logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rdStrobe = 1'b1;
    #1 v = rdData;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  // Flip pins, then wait through synchronizer and pending flop
  task automatic togglePins(logic [7:0] m);
    @(negedge clk); pins = pins ^ m;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    pins = 8'h00; od = 8'h00; addr = 8'h00; wrData = 8'h00;
    wrStrobe = 1'b0; rdStrobe = 1'b0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irqN", {7'b0, irqN}, 8'h01);
    check("R1 pullUpEn", pullUpEn, 8'h00);
    check("R1 pullDnEn", pullDnEn, 8'h00);
    readReg(8'h42, v); check("R1 latch", v, 8'h00);
    readReg(8'h43, v); check("R1 pullEn", v, 8'h00);
    readReg(8'h44, v); check("R1 pullSel", v, 8'h00);
    readReg(8'h45, v); check("R1 mask", v, 8'hFF);

    // Per-pin interrupt sweep: R2, R3, R4, R5, R6
    for (int i = 0; i < 8; i++) begin
      logic [7:0] bitM;
      bitM = 8'h01 << i;
      writeReg(8'h45, ~bitM);
      togglePins(bitM);
      check("R2 unmasked change", {7'b0, irqN}, 8'h00);
      readReg(8'h00, v);
      check("R6 port value", v, pins);
      check("R6 irq released", {7'b0, irqN}, 8'h01);

      writeReg(8'h45, 8'hFF);
      togglePins(bitM);
      check("R3 masked change", {7'b0, irqN}, 8'h01);
      writeReg(8'h45, ~bitM);
      check("R4 unmask pending", {7'b0, irqN}, 8'h00);
      writeReg(8'h45, 8'hFF);
      check("R5 mask source", {7'b0, irqN}, 8'h01);
      readReg(8'h00, v);
    end

    // R5 with a second source still pending
    writeReg(8'h45, 8'hF9);
    togglePins(8'h06);
    check("R5 two sources", {7'b0, irqN}, 8'h00);
    writeReg(8'h45, 8'hFB);
    check("R5 other still pending", {7'b0, irqN}, 8'h00);
    writeReg(8'h45, 8'hFF);
    check("R5 all masked", {7'b0, irqN}, 8'h01);
    readReg(8'h00, v);
    check("R6 cleared pins", v, pins);
    togglePins(pins);
    readReg(8'h00, v);

    // R7 latched versus live port value
    writeReg(8'h42, 8'h08);
    togglePins(8'h18);
    togglePins(8'h18);
    readReg(8'h00, v);
    check("R7 latched glitch", v, 8'h08);
    readReg(8'h00, v);
    check("R7 after clear", v, 8'h00);
    writeReg(8'h42, 8'h00);

    // R11 readback
    writeReg(8'h42, 8'hA5); writeReg(8'h43, 8'h3C);
    writeReg(8'h44, 8'h0F); writeReg(8'h45, 8'hF0);
    readReg(8'h42, v); check("R11 latch", v, 8'hA5);
    readReg(8'h43, v); check("R11 pullEn", v, 8'h3C);
    readReg(8'h44, v); check("R11 pullSel", v, 8'h0F);
    readReg(8'h45, v); check("R11 mask", v, 8'hF0);

    // R10 unmapped access
    writeReg(8'h46, 8'h55); writeReg(8'h00, 8'hAA); writeReg(8'h41, 8'h00);
    readReg(8'h42, v); check("R10 latch kept", v, 8'hA5);
    readReg(8'h43, v); check("R10 pullEn kept", v, 8'h3C);
    readReg(8'h44, v); check("R10 pullSel kept", v, 8'h0F);
    readReg(8'h45, v); check("R10 mask kept", v, 8'hF0);
    readReg(8'h46, v); check("R10 read 46h", v, 8'h00);
    readReg(8'h41, v); check("R10 read 41h", v, 8'h00);
    readReg(8'hFF, v); check("R10 read FFh", v, 8'h00);
    writeReg(8'h42, 8'h00); writeReg(8'h45, 8'hFF);

    // R8 and R9 sweep over all enable patterns
    for (int e = 0; e < 256; e++) begin
      logic [7:0] en, sel;
      en  = 8'(e);
      sel = en ^ 8'h96;
      od  = 8'(e * 37) & 8'h11;
      writeReg(8'h43, en);
      writeReg(8'h44, sel);
      check("R8 R9 pullUp sweep", pullUpEn, en & sel & ~od);
      check("R8 R9 pullDn sweep", pullDnEn, en & ~sel & ~od);
    end

    // R9 dedicated open-drain cases
    writeReg(8'h43, 8'hFF); writeReg(8'h44, 8'hF0);
    @(negedge clk); od = 8'h0F; #1;
    check("R9 up od low nibble", pullUpEn, 8'hF0);
    check("R9 dn od low nibble", pullDnEn, 8'h00);
    @(negedge clk); od = 8'hF0; #1;
    check("R9 up od high nibble", pullUpEn, 8'h00);
    check("R9 dn od high nibble", pullDnEn, 8'h0F);
    @(negedge clk); od = 8'h00; #1;
    check("R8 up all enabled", pullUpEn, 8'hF0);
    check("R8 dn all enabled", pullDnEn, 8'h0F);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule